// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block gives a CPU-side register port over a small fuse store of 128 words of 32 bits. The lower 64 words form the primary bank and the upper 64 words hold a redundant copy; software reads or programs each bank on its own. The fuse store here is a behavioural register array. Programming can only set bits to 1 and can never clear them.

Software writes a byte address and, for programming, a data word. It then writes the control register with a 12-bit unlock key and one start bit. The operation runs for a fixed number of cycles. During that time the start bit reads back as a busy flag, and it drops to 0 when the operation is complete. A 4-bit state code in the control register shows whether the controller is coming out of reset, idle, programming or reading. A sticky lock bit in the same register holds its value until reset.

The register port has a select, a write enable, an 8-bit byte offset and 32-bit data. Reads are combinational while select is high and write enable is low. In every other cycle the read port returns 0.

Top module: `otpf_ctrl`

## Requirements
- R1: After reset, the state field (control bits [11:8]) reads 1 for exactly 16 cycles and then reads 2 (idle). Reset clears the fuse array and the address, write-data, read-data and lock registers. A start request written before the state reaches idle is ignored.
- R2: A read starts when the control register (offset 0x00) is written with bits [27:16] = 0xA1C and bit 4 = 1 while the state is idle. Bit 4 then reads 1 and the state reads 4 for 4 cycles. After that, bit 4 reads 0, the state reads 2, and the read-data register (offset 0x0C) holds the addressed word.
- R3: A program operation starts when the control register is written with bits [27:16] = 0xA1C and bit 0 = 1 while the state is idle. Bit 0 then reads 1 and the state reads 3 for 8 cycles. After that, the addressed word equals its old value OR the write data, and no fuse bit ever returns from 1 to 0.
- R4: A control write whose bits [27:16] differ from 0xA1C starts nothing: the state stays 2, both start bits read 0, and no fuse word or read-data value changes.
- R5: The address register (offset 0x04) holds a byte address. Bits [1:0] read as 0. The word index is address bits [8:2]. Indices 0 to 63 select the primary bank and indices 64 to 127 select the redundant bank, and every word is independent of all the others. The write-data register is at offset 0x08.
- R6: If any address bit above bit 8 is set, the operation still runs for its full length. A program operation then changes no fuse word, and a read loads 0 into the read-data register.
- R7: A start request that arrives while an operation is running is ignored. The address and write data are captured when the operation starts, so register writes made during the operation do not affect it.
- R8: If one control write sets both bit 4 and bit 0 together with the correct key, only the read runs.
- R9: Control bit 28 is a lock bit. Any control write with bit 28 = 1 sets it, with or without the key. After that it reads 1 until reset, whatever value is written to it.
- R10: The timing register (offset 0x10) is read-only and reads 0x0000_0804. Bits [15:8] hold the program length in cycles and bits [7:0] hold the read length in cycles.
- R11: The read-data register changes only in the cycle in which a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when no read is selected |

## Verification
The bench aims at the cases where a controller tends to fail:
- A start request written during the power-up window or in the middle of a running operation. A design that accepts it would change the busy flags or leave an extra mark in a fuse word.
- Repeated programming of the same word. A design that writes the data instead of ORing it would drop bits that are already blown.
- Addresses one word past the top of the array and far above it. A design that truncates the address would alias onto word 0, and a read would return that word's data instead of 0.
- A start command with both start bits set and address or data rewritten while it runs. A design that picks the wrong command or uses the live registers would program an unintended word.

// File: rtl/otpf_pkg.sv
package otpf_pkg;

    typedef enum logic [3:0] {
        ST_INIT = 4'd1,
        ST_IDLE = 4'd2,
        ST_PROG = 4'd3,
        ST_READ = 4'd4
    } otpf_state_e;

    localparam logic [11:0] OTPF_KEY = 12'hA1C;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_ADDR  = 8'h04;
    localparam logic [7:0] OFF_WDATA = 8'h08;
    localparam logic [7:0] OFF_RDATA = 8'h0C;
    localparam logic [7:0] OFF_TIME  = 8'h10;

    localparam int BIT_PG    = 0;
    localparam int BIT_RD    = 4;
    localparam int ST_LSB    = 8;
    localparam int KEY_LSB   = 16;
    localparam int BIT_LOCK  = 28;

    typedef struct packed {
        logic        sel;
        logic        we;
        logic [7:0]  off;
        logic [31:0] wdata;
    } otpf_req_t;

    function automatic logic [31:0] pack_ctrl(input logic lock, input logic [3:0] st,
                                              input logic rd, input logic pg);
        logic [31:0] v;
        v = '0;
        v[BIT_LOCK]         = lock;
        v[ST_LSB +: 4]      = st;
        v[BIT_RD]           = rd;
        v[BIT_PG]           = pg;
        return v;
    endfunction

    function automatic logic key_match(input logic [31:0] w);
        return w[KEY_LSB +: 12] == OTPF_KEY;
    endfunction

endpackage

// File: rtl/otpf_array.sv
module otpf_array #(
    parameter int WORDS = 128,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DW-1:0]       set_bits,
    output logic [DW-1:0]       word_out,
    output logic [WORDS*DW-1:0] mem_view
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (set_en) begin
            mem[idx] <= mem[idx] | set_bits;
        end
    end

    assign word_out = mem[idx];

    for (genvar g = 0; g < WORDS; g++) begin : g_view
        assign mem_view[g*DW +: DW] = mem[g];
    end
endmodule

// File: rtl/otpf_seq.sv
module otpf_seq
    import otpf_pkg::*;
#(
    parameter int WORDS    = 128,
    parameter int DW       = 32,
    parameter int INIT_CYC = 16,
    parameter int RD_CYC   = 4,
    parameter int PG_CYC   = 8,
    localparam int IDX_W   = $clog2(WORDS),
    localparam int MAXC    = (INIT_CYC > RD_CYC) ? ((INIT_CYC > PG_CYC) ? INIT_CYC : PG_CYC)
                                                 : ((RD_CYC > PG_CYC) ? RD_CYC : PG_CYC),
    localparam int CW      = $clog2(MAXC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_go,
    input  logic             pg_go,
    input  logic [29:0]      word_addr,
    input  logic [DW-1:0]    wdata,
    output otpf_state_e      state,
    output logic             rd_busy,
    output logic             pg_busy,
    output logic             rd_done,
    output logic             pg_done,
    output logic [IDX_W-1:0] op_idx,
    output logic             op_ok,
    output logic [DW-1:0]    op_wdata
);
    otpf_state_e   state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_INIT;
            cnt_q    <= '0;
            op_idx   <= '0;
            op_ok    <= 1'b0;
            op_wdata <= '0;
        end else begin
            case (state_q)
                ST_INIT: begin
                    if (cnt_q == CW'(INIT_CYC - 1)) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (rd_go || pg_go) begin
                        state_q  <= rd_go ? ST_READ : ST_PROG;
                        cnt_q    <= rd_go ? CW'(RD_CYC - 1) : CW'(PG_CYC - 1);
                        op_idx   <= word_addr[IDX_W-1:0];
                        op_ok    <= (word_addr >> IDX_W) == '0;
                        op_wdata <= wdata;
                    end
                end
                default: begin
                    if (cnt_q == '0) state_q <= ST_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    assign state   = state_q;
    assign rd_busy = (state_q == ST_READ);
    assign pg_busy = (state_q == ST_PROG);
    assign rd_done = rd_busy && (cnt_q == '0);
    assign pg_done = pg_busy && (cnt_q == '0);
endmodule

// File: rtl/otpf_regbank.sv
module otpf_regbank
    import otpf_pkg::*;
#(
    parameter int RD_CYC = 4,
    parameter int PG_CYC = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  otpf_req_t   req,
    input  otpf_state_e state,
    input  logic        rd_busy,
    input  logic        pg_busy,
    input  logic        rd_upd,
    input  logic [31:0] rd_val,
    output logic [31:0] bus_rdata,
    output logic [29:0] addr_q,
    output logic [31:0] wdata_q,
    output logic [31:0] rdata_q,
    output logic        lock_q,
    output logic        rd_go,
    output logic        pg_go
);
    logic wr_hit;
    logic ctrl_wr;
    logic key_ok;

    assign wr_hit  = req.sel && req.we;
    assign ctrl_wr = wr_hit && (req.off == OFF_CTRL);
    assign key_ok  = key_match(req.wdata);
    assign rd_go   = ctrl_wr && key_ok && req.wdata[BIT_RD];
    assign pg_go   = ctrl_wr && key_ok && req.wdata[BIT_PG];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            lock_q  <= 1'b0;
        end else begin
            if (wr_hit) begin
                case (req.off)
                    OFF_ADDR:  addr_q  <= req.wdata[31:2];
                    OFF_WDATA: wdata_q <= req.wdata;
                    OFF_CTRL:  if (req.wdata[BIT_LOCK]) lock_q <= 1'b1;
                    default: ;
                endcase
            end
            if (rd_upd) rdata_q <= rd_val;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (req.sel && !req.we) begin
            case (req.off)
                OFF_CTRL:  bus_rdata = pack_ctrl(lock_q, state, rd_busy, pg_busy);
                OFF_ADDR:  bus_rdata = {addr_q, 2'b00};
                OFF_WDATA: bus_rdata = wdata_q;
                OFF_RDATA: bus_rdata = rdata_q;
                OFF_TIME:  bus_rdata = {16'h0, 8'(PG_CYC), 8'(RD_CYC)};
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/otpf_ctrl.sv
module otpf_ctrl
    import otpf_pkg::*;
#(
    parameter int WORDS    = 128,
    parameter int DW       = 32,
    parameter int INIT_CYC = 16,
    parameter int RD_CYC   = 4,
    parameter int PG_CYC   = 8,
    localparam int IDX_W   = $clog2(WORDS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_off,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    otpf_req_t          req;
    otpf_state_e        state_w;
    logic               rd_busy, pg_busy, rd_done, pg_done;
    logic               rd_go, pg_go, lock_q, op_ok;
    logic [29:0]        addr_q;
    logic [31:0]        wdata_q, rdata_q, rd_val;
    logic [IDX_W-1:0]   op_idx;
    logic [DW-1:0]      op_wdata, arr_word;
    logic [WORDS*DW-1:0] mem_view;

    assign req = '{sel: bus_sel, we: bus_we, off: bus_off, wdata: bus_wdata};

    otpf_regbank #(.RD_CYC(RD_CYC), .PG_CYC(PG_CYC)) u_regs (
        .clk(clk), .rst(rst), .req(req), .state(state_w),
        .rd_busy(rd_busy), .pg_busy(pg_busy),
        .rd_upd(rd_done), .rd_val(rd_val),
        .bus_rdata(bus_rdata), .addr_q(addr_q), .wdata_q(wdata_q),
        .rdata_q(rdata_q), .lock_q(lock_q), .rd_go(rd_go), .pg_go(pg_go)
    );

    otpf_seq #(.WORDS(WORDS), .DW(DW), .INIT_CYC(INIT_CYC),
               .RD_CYC(RD_CYC), .PG_CYC(PG_CYC)) u_seq (
        .clk(clk), .rst(rst), .rd_go(rd_go), .pg_go(pg_go),
        .word_addr(addr_q), .wdata(wdata_q[DW-1:0]),
        .state(state_w), .rd_busy(rd_busy), .pg_busy(pg_busy),
        .rd_done(rd_done), .pg_done(pg_done),
        .op_idx(op_idx), .op_ok(op_ok), .op_wdata(op_wdata)
    );

    otpf_array #(.WORDS(WORDS), .DW(DW)) u_fuse (
        .clk(clk), .rst(rst), .set_en(pg_done && op_ok), .idx(op_idx),
        .set_bits(op_wdata), .word_out(arr_word), .mem_view(mem_view)
    );

    assign rd_val = op_ok ? 32'(arr_word) : 32'h0;
endmodule

// File: rtl/otpf_ctrl_chk.sv
module otpf_ctrl_chk
    import otpf_pkg::*;
#(
    parameter int WORDS  = 128,
    parameter int DW     = 32,
    parameter int RD_CYC = 4,
    parameter int PG_CYC = 8
) (
    input logic                clk,
    input logic                rst,
    input otpf_state_e         state,
    input logic                rd_busy,
    input logic                pg_busy,
    input logic                rd_done,
    input logic                lock_q,
    input logic [31:0]         rdata_q,
    input logic [WORDS*DW-1:0] mem_view
);
    int rd_run, pg_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_run <= 0;
            pg_run <= 0;
        end else begin
            rd_run <= rd_busy ? rd_run + 1 : 0;
            pg_run <= pg_busy ? pg_run + 1 : 0;
        end
    end

    a_r1_state_legal: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INIT || state == ST_IDLE || state == ST_PROG || state == ST_READ));

    a_r1_no_op_in_init: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INIT) |-> !(rd_busy || pg_busy));

    a_r2_read_length: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_busy) |-> (rd_run == RD_CYC));

    a_r3_prog_length: assert property (@(posedge clk) disable iff (rst)
        $fell(pg_busy) |-> (pg_run == PG_CYC));

    a_r3_fuse_only_sets: assert property (@(posedge clk) disable iff (rst)
        (($past(mem_view) & ~mem_view) == '0));

    a_r8_one_op: assert property (@(posedge clk) disable iff (rst)
        !(rd_busy && pg_busy));

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_done |=> $stable(rdata_q));
endmodule

bind otpf_ctrl otpf_ctrl_chk #(.WORDS(WORDS), .DW(DW), .RD_CYC(RD_CYC), .PG_CYC(PG_CYC)) u_chk (
    .clk(clk), .rst(rst), .state(state_w), .rd_busy(rd_busy), .pg_busy(pg_busy),
    .rd_done(rd_done), .lock_q(lock_q), .rdata_q(rdata_q), .mem_view(mem_view)
);

// File: tb/otpf_ctrl_tb_top.sv
module otpf_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = CLK_PERIOD / 4;
    localparam logic [31:0] KEY = 32'h0A1C_0000;
    localparam logic [7:0] O_CTRL = 8'h00, O_ADDR = 8'h04, O_WD = 8'h08,
                           O_RD = 8'h0C, O_TIME = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, we = 1'b0;
    logic [7:0]  off = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    logic [31:0] exp_val_q[$];
    string       exp_tag_q[$];
    event        smp_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    otpf_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we),
        .bus_off(off), .bus_wdata(wdata), .bus_rdata(rdata)
    );

    // scoreboard monitor
    initial forever begin
        @(smp_ev);
        begin
            logic [31:0] e;
            string t;
            e = exp_val_q.pop_front();
            t = exp_tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic bus_wr(input logic [7:0] o, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; off = o; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] o, input logic [31:0] v, input string tag);
        exp_val_q.push_back(v);
        exp_tag_q.push_back(tag);
        sel = 1'b1; we = 1'b0; off = o;
        #(QTR);
        -> smp_ev;
        #1;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic wait_op(output int n);
        logic [31:0] v;
        n = 0;
        forever begin
            sel = 1'b1; we = 1'b0; off = O_CTRL;
            #(QTR);
            v = rdata;
            if (!v[4] && !v[0] && v[11:8] == 4'd2) break;
            @(negedge clk);
            n++;
            if (n > 100) break;
        end
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic do_prog(input logic [31:0] a, input logic [31:0] d);
        int n;
        bus_wr(O_ADDR, a);
        bus_wr(O_WD, d);
        bus_wr(O_CTRL, KEY | 32'h1);
        wait_op(n);
        check_eq("R3 program lasts 8 cycles", n, 8);
    endtask

    task automatic do_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
        int n;
        bus_wr(O_ADDR, a);
        bus_wr(O_CTRL, KEY | 32'h10);
        wait_op(n);
        check_eq("R2 read lasts 4 cycles", n, 4);
        expect_reg(O_RD, exp, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: start during init ignored
        bus_wr(O_CTRL, KEY | 32'h10);
        expect_reg(O_CTRL, 32'h0000_0100, "R1 start ignored while initializing");
        expect_reg(O_ADDR, 32'h0, "R1 address reset");
        expect_reg(O_WD, 32'h0, "R1 write data reset");
        expect_reg(O_RD, 32'h0, "R1 read data reset");
        expect_reg(O_TIME, 32'h0000_0804, "R10 timing register");
        repeat (9) @(negedge clk);
        expect_reg(O_CTRL, 32'h0000_0100, "R1 still initializing after 15 cycles");
        expect_reg(O_CTRL, 32'h0000_0200, "R1 idle after 16 cycles");

        // R3 / R2 program and OR
        do_prog(32'h14, 32'h0000_00F0);
        do_read(32'h14, 32'h0000_00F0, "R2 read back programmed word");
        do_prog(32'h14, 32'h0F00_0003);
        do_read(32'h14, 32'h0F00_00F3, "R3 program ORs into word");
        expect_reg(O_ADDR, 32'h14, "R5 address register read back");

        // R5 banks
        do_read(32'h114, 32'h0, "R5 redundant word independent");
        do_prog(32'h114, 32'hAAAA_0000);
        do_read(32'h114, 32'hAAAA_0000, "R5 redundant word programmed");
        do_read(32'h14, 32'h0F00_00F3, "R5 primary word untouched");
        do_prog(32'h1FC, 32'h8000_0001);
        do_prog(32'h0, 32'h1);
        do_read(32'h0, 32'h1, "R5 word 0");

        // R4 wrong key
        bus_wr(O_ADDR, 32'h0);
        bus_wr(O_WD, 32'hFFFF_FFFF);
        bus_wr(O_CTRL, 32'h0A1D_0001);
        expect_reg(O_CTRL, 32'h0000_0200, "R4 wrong key program ignored");
        bus_wr(O_ADDR, 32'h14);
        bus_wr(O_CTRL, 32'h0A1D_0010);
        expect_reg(O_CTRL, 32'h0000_0200, "R4 wrong key read ignored");
        expect_reg(O_RD, 32'h1, "R4 read data unchanged");
        do_read(32'h0, 32'h1, "R4 word unchanged by bad key");

        // R6 out of range
        do_prog(32'h200, 32'hFFFF_FFFF);
        do_read(32'h1FC, 32'h8000_0001, "R6 last word in range");
        do_read(32'h200, 32'h0, "R6 out-of-range read gives 0");
        do_read(32'h0, 32'h1, "R6 no alias onto word 0");
        do_read(32'h14, 32'h0F00_00F3, "R6 reload");
        do_read(32'h8000_0014, 32'h0, "R6 high address bit");

        // R7 / R11 busy during read
        do_read(32'h0, 32'h1, "R7 setup");
        bus_wr(O_WD, 32'h0000_5555);
        bus_wr(O_ADDR, 32'h14);
        bus_wr(O_CTRL, KEY | 32'h10);
        bus_wr(O_ADDR, 32'h114);
        bus_wr(O_CTRL, KEY | 32'h1);
        expect_reg(O_RD, 32'h1, "R11 read data held during read");
        wait_op(n);
        expect_reg(O_RD, 32'h0F00_00F3, "R7 read used captured address");
        do_read(32'h114, 32'hAAAA_0000, "R7 program during read ignored");

        // R7 program operands captured
        bus_wr(O_ADDR, 32'h0);
        bus_wr(O_WD, 32'h10);
        bus_wr(O_CTRL, KEY | 32'h1);
        bus_wr(O_ADDR, 32'h1FC);
        bus_wr(O_WD, 32'hFFFF_FFFF);
        wait_op(n);
        do_read(32'h0, 32'h11, "R7 program used captured operands");
        do_read(32'h1FC, 32'h8000_0001, "R7 other word untouched");

        // R8 both start bits
        do_read(32'h0, 32'h11, "R8 setup");
        bus_wr(O_ADDR, 32'h114);
        bus_wr(O_WD, 32'h1);
        bus_wr(O_CTRL, KEY | 32'h11);
        wait_op(n);
        check_eq("R8 both bits run a read", n, 4);
        expect_reg(O_RD, 32'hAAAA_0000, "R8 read result");
        do_read(32'h114, 32'hAAAA_0000, "R8 no program performed");

        // R9 lock
        expect_reg(O_CTRL, 32'h0000_0200, "R9 lock clear");
        bus_wr(O_CTRL, 32'h1000_0000);
        expect_reg(O_CTRL, 32'h1000_0200, "R9 lock set");
        bus_wr(O_CTRL, 32'h0);
        expect_reg(O_CTRL, 32'h1000_0200, "R9 lock sticky");
        bus_wr(O_CTRL, KEY | 32'h10);
        wait_op(n);
        expect_reg(O_CTRL, 32'h1000_0200, "R9 lock kept over a read");

        // reset clears
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_reg(O_CTRL, 32'h0000_0100, "R9 lock cleared by reset, R1 init");
        repeat (20) @(negedge clk);
        do_read(32'h14, 32'h0, "R1 array blank after reset");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule